// File: doc/BRIEF.md
# Two-Command Memory Request Sequencer

This block sits on the controller side of a DRAM that accepts every operation as a back-to-back pair of commands. A user presents one request at a time: read, write, auto-refresh or mode register programming. The sequencer turns it into a first command, which carries the bank and the upper address, and a second command on the very next clock, which carries the lower address and decides what the pair means. The slot for the second command can never be taken by anything else. In every other cycle the command bus carries deselect.

Each bank has a busy timer that starts when a read or write pair starts on it. A new pair goes only to a bank whose timer has run out. Refresh and mode programming wait until every bank is idle and no data window is pending. After each access pair the block raises a read-valid window or a write data-enable and strobe window on the clock grid, relative to the second command. It also drives a low-active power-down pin when asked, and it holds off new commands for a programmable number of deselect cycles after wake-up.

Top module: `pair_cmd_seq`

## Requirements
- R1: A read request (type 0) produces the first command code 1 with the request bank on `ba_o` and the upper address on `addr_o`. The next cycle carries code 3 with the same bank and the lower address, zero-extended. `req_grant_o` is high only in cycles that carry code 1 or 2 as the first command of a pair.
- R2: A write request (type 1) produces code 2 with the bank and upper address. The next cycle carries code 3 with the bank, the lower address and `vw_o` equal to the request's burst select. `vw_o` is 0 on every other command.
- R3: A refresh request (type 2) produces code 2 followed by code 4, with the request bank and upper address on the first command and address 0 on the second. It is granted only once all bank timers have expired and no data window is pending or active.
- R4: A mode request (type 3) produces code 1 followed by code 5. Both commands carry the request bank as the register select and the upper address as the mode data. It has the same all-idle condition as R3.
- R5: After a read or write pair starts on a bank in cycle k, no new pair starts on that bank before cycle k+T_IRC.
- R6: After a refresh pair starts in cycle k, no pair of any kind starts before cycle k+1+T_IREFC.
- R7: After a write's second command in cycle t, `wr_dq_en_o` is high in cycles t+CL-1 through t+CL-2+2^vw. `wr_strobe_o` is high in the first of those cycles, alternates each cycle after that, and is low outside the window.
- R8: After a read's second command in cycle t, `rd_valid_o` is high in cycles t+CL through t+CL+RD_BURST-1 and low otherwise.
- R9: A new pair starts no earlier than the second cycle after the last cycle of the previous data window. When nothing blocks a request, a pair starts two cycles after the previous first command.
- R10: Command codes are 0 deselect, 1 read-open, 2 write-open, 3 lower address, 4 refresh, 5 mode set. Code 0 is driven in every cycle that carries no pair command. After reset `pd_o` is 1 and every other output is 0.
- R11: While `pd_req_i` is high no request is granted. `pd_o` goes low in the cycle after the first clock edge at which all banks are idle and no window is pending, and only deselect is driven while it is low.
- R12: When `pd_req_i` falls, `pd_o` returns high in the next cycle p. The earliest following first command is in cycle p+T_PDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_type_i | input | 2 | 0 read, 1 write, 2 refresh, 3 mode set |
| req_bank_i | input | BA_W | Target bank or mode register select |
| req_uaddr_i | input | UA_W | Upper address or mode data |
| req_laddr_i | input | LA_W | Lower address |
| req_vw_i | input | 2 | Write burst select, burst of 2^vw clocks |
| req_grant_o | output | 1 | Request accepted; high with the first command |
| pd_req_i | input | 1 | Level request for power-down |
| cmd_o | output | 3 | Command code |
| ba_o | output | BA_W | Bank address |
| addr_o | output | UA_W | Address bus |
| vw_o | output | 2 | Write burst bits, sent with the lower-address command |
| pd_o | output | 1 | Power-down pin, low means powered down |
| rd_valid_o | output | 1 | Read data expected this cycle |
| wr_dq_en_o | output | 1 | Drive write data this cycle |
| wr_strobe_o | output | 1 | Write strobe level |

## Verification
The bench builds the block with CL=3, RD_BURST=2, T_IRC=10, T_IREFC=12 and T_PDA=3. These values make the bank timer outlast the data-bus wait: a repeat access to the same bank lands ten cycles after the first, while an access to another bank lands seven cycles after it. This tells the two blocking rules apart. Refresh then has to wait for the slowest bank. Because the refresh hold-off is longer than the bank time, the refresh-to-mode gap shows up on its own, and a short wake-up count keeps the power-down exit timing easy to see.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    CMD_DESL = 3'd0,
    CMD_RDA  = 3'd1,
    CMD_WRA  = 3'd2,
    CMD_LAL  = 3'd3,
    CMD_REF  = 3'd4,
    CMD_MRS  = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    REQ_READ    = 2'd0,
    REQ_WRITE   = 2'd1,
    REQ_REFRESH = 2'd2,
    REQ_MODE    = 2'd3
  } req_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SECOND,
    ST_PDOWN,
    ST_PDEXIT
  } st_e;

endpackage

// File: rtl/pcs_bank_timers.sv
module pcs_bank_timers #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int TW        = 6,
  parameter int T_IRC     = 14,
  parameter int T_IREFC   = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_one_i,
  input  logic                 ld_all_i,
  input  logic [BA_W-1:0]      ld_bank_i,
  output logic [NUM_BANKS-1:0] idle_o
);

  localparam logic [TW-1:0] LD_ACCESS  = TW'(T_IRC - 1);
  localparam logic [TW-1:0] LD_REFRESH = TW'(T_IREFC);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
      end else if (ld_all_i) begin
        cnt <= LD_REFRESH;
      end else if (ld_one_i && (ld_bank_i == BA_W'(b))) begin
        cnt <= LD_ACCESS;
      end else if (cnt != '0) begin
        cnt <= cnt - TW'(1);
      end
    end

    assign idle_o[b] = (cnt == '0);
  end

endmodule

// File: rtl/pcs_data_window.sv
module pcs_data_window #(
  parameter int CL    = 4,
  parameter int OFF_W = 3,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch_i,
  input  logic             launch_rd_i,
  input  logic [LEN_W-1:0] launch_len_i,
  output logic             busy_o,
  output logic             rd_valid_o,
  output logic             wr_en_o,
  output logic             wr_strobe_o
);

  localparam logic [OFF_W-1:0] OFF_RD = OFF_W'(CL);
  localparam logic [OFF_W-1:0] OFF_WR = OFF_W'(CL - 1);

  logic [OFF_W-1:0] wait_cnt;
  logic [LEN_W-1:0] pend_len;
  logic             pend_rd;
  logic [LEN_W-1:0] len_cnt;
  logic             active_q;
  logic             rd_q;
  logic             we_q;
  logic             st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
      pend_len <= '0;
      pend_rd  <= 1'b0;
      len_cnt  <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      we_q     <= 1'b0;
      st_q     <= 1'b0;
    end else if (launch_i) begin
      wait_cnt <= launch_rd_i ? OFF_RD : OFF_WR;
      pend_len <= launch_len_i;
      pend_rd  <= launch_rd_i;
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - OFF_W'(1);
      if (wait_cnt == OFF_W'(1)) begin
        active_q <= 1'b1;
        len_cnt  <= pend_len;
        rd_q     <= pend_rd;
        we_q     <= ~pend_rd;
        st_q     <= ~pend_rd;
      end
    end else if (active_q) begin
      if (len_cnt == LEN_W'(1)) begin
        active_q <= 1'b0;
        len_cnt  <= '0;
        rd_q     <= 1'b0;
        we_q     <= 1'b0;
        st_q     <= 1'b0;
      end else begin
        len_cnt <= len_cnt - LEN_W'(1);
        st_q    <= we_q ? ~st_q : 1'b0;
      end
    end
  end

  assign busy_o      = (wait_cnt != '0) || active_q;
  assign rd_valid_o  = rd_q;
  assign wr_en_o     = we_q;
  assign wr_strobe_o = st_q;

endmodule

// File: rtl/pcs_issue.sv
module pcs_issue
  import pcs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int UA_W      = 15,
  parameter int LA_W      = 10,
  parameter int RD_BURST  = 4,
  parameter int T_PDA     = 6,
  parameter int LEN_W     = 4,
  parameter int PDC_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_type_i,
  input  logic [BA_W-1:0]      req_bank_i,
  input  logic [UA_W-1:0]      req_uaddr_i,
  input  logic [LA_W-1:0]      req_laddr_i,
  input  logic [1:0]           req_vw_i,
  input  logic                 pd_req_i,
  input  logic [NUM_BANKS-1:0] bank_idle_i,
  input  logic                 bus_busy_i,
  output logic                 grant_o,
  output logic [2:0]           cmd_o,
  output logic [BA_W-1:0]      ba_o,
  output logic [UA_W-1:0]      addr_o,
  output logic [1:0]           vw_o,
  output logic                 pd_o,
  output logic                 ld_one_o,
  output logic                 ld_all_o,
  output logic [BA_W-1:0]      ld_bank_o,
  output logic                 launch_o,
  output logic                 launch_rd_o,
  output logic [LEN_W-1:0]     launch_len_o
);

  st_e              state;
  cmd_e             cmd_q;
  req_e             held_type;
  logic [BA_W-1:0]  held_bank;
  logic [UA_W-1:0]  held_uaddr;
  logic [LA_W-1:0]  held_laddr;
  logic [1:0]       held_vw;
  logic [PDC_W-1:0] pdc;

  req_e rtype;
  logic can_decide;
  logic all_idle;
  logic quiet;
  logic is_ctl;
  logic eligible;
  logic enter_pd;
  logic take;

  always_comb begin
    rtype      = req_e'(req_type_i);
    can_decide = (state == ST_IDLE) || ((state == ST_PDEXIT) && (pdc == '0));
    all_idle   = &bank_idle_i;
    quiet      = all_idle && !bus_busy_i;
    is_ctl     = (rtype == REQ_REFRESH) || (rtype == REQ_MODE);
    eligible   = req_valid_i && !bus_busy_i &&
                 (is_ctl ? all_idle : bank_idle_i[req_bank_i]);
    enter_pd   = can_decide && pd_req_i && quiet;
    take       = can_decide && !pd_req_i && eligible;
  end

  assign ld_one_o     = take && !is_ctl;
  assign ld_all_o     = take && (rtype == REQ_REFRESH);
  assign ld_bank_o    = req_bank_i;
  assign launch_o     = (state == ST_SECOND) &&
                        ((held_type == REQ_READ) || (held_type == REQ_WRITE));
  assign launch_rd_o  = (held_type == REQ_READ);
  assign launch_len_o = (held_type == REQ_READ) ? LEN_W'(RD_BURST)
                                                : (LEN_W'(1) << held_vw);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cmd_q      <= CMD_DESL;
      grant_o    <= 1'b0;
      ba_o       <= '0;
      addr_o     <= '0;
      vw_o       <= '0;
      pd_o       <= 1'b1;
      pdc        <= '0;
      held_type  <= REQ_READ;
      held_bank  <= '0;
      held_uaddr <= '0;
      held_laddr <= '0;
      held_vw    <= '0;
    end else begin
      grant_o <= 1'b0;
      cmd_q   <= CMD_DESL;
      ba_o    <= '0;
      addr_o  <= '0;
      vw_o    <= '0;
      case (state)
        ST_IDLE, ST_PDEXIT: begin
          if ((state == ST_PDEXIT) && (pdc != '0)) begin
            pdc <= pdc - PDC_W'(1);
          end
          if (enter_pd) begin
            state <= ST_PDOWN;
            pd_o  <= 1'b0;
          end else if (take) begin
            state      <= ST_SECOND;
            grant_o    <= 1'b1;
            cmd_q      <= ((rtype == REQ_WRITE) || (rtype == REQ_REFRESH)) ? CMD_WRA : CMD_RDA;
            ba_o       <= req_bank_i;
            addr_o     <= req_uaddr_i;
            held_type  <= rtype;
            held_bank  <= req_bank_i;
            held_uaddr <= req_uaddr_i;
            held_laddr <= req_laddr_i;
            held_vw    <= req_vw_i;
          end
        end
        ST_SECOND: begin
          state <= ST_IDLE;
          ba_o  <= held_bank;
          case (held_type)
            REQ_READ: begin
              cmd_q  <= CMD_LAL;
              addr_o <= UA_W'(held_laddr);
            end
            REQ_WRITE: begin
              cmd_q  <= CMD_LAL;
              addr_o <= UA_W'(held_laddr);
              vw_o   <= held_vw;
            end
            REQ_REFRESH: begin
              cmd_q  <= CMD_REF;
            end
            default: begin
              cmd_q  <= CMD_MRS;
              addr_o <= held_uaddr;
            end
          endcase
        end
        default: begin
          if (!pd_req_i) begin
            state <= ST_PDEXIT;
            pd_o  <= 1'b1;
            pdc   <= PDC_W'(T_PDA - 1);
          end
        end
      endcase
    end
  end

  assign cmd_o = cmd_q;

endmodule

// File: rtl/pair_cmd_seq.sv
module pair_cmd_seq #(
  parameter int BA_W     = 2,
  parameter int UA_W     = 15,
  parameter int LA_W     = 10,
  parameter int CL       = 4,
  parameter int RD_BURST = 4,
  parameter int T_IRC    = 14,
  parameter int T_IREFC  = 40,
  parameter int T_PDA    = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid_i,
  input  logic [1:0]      req_type_i,
  input  logic [BA_W-1:0] req_bank_i,
  input  logic [UA_W-1:0] req_uaddr_i,
  input  logic [LA_W-1:0] req_laddr_i,
  input  logic [1:0]      req_vw_i,
  output logic            req_grant_o,
  input  logic            pd_req_i,
  output logic [2:0]      cmd_o,
  output logic [BA_W-1:0] ba_o,
  output logic [UA_W-1:0] addr_o,
  output logic [1:0]      vw_o,
  output logic            pd_o,
  output logic            rd_valid_o,
  output logic            wr_dq_en_o,
  output logic            wr_strobe_o
);

  localparam int NUM_BANKS = 1 << BA_W;
  localparam int T_MAX     = (T_IRC > T_IREFC) ? T_IRC : T_IREFC;
  localparam int TW        = $clog2(T_MAX + 1);
  localparam int LEN_MAX   = (RD_BURST > 8) ? RD_BURST : 8;
  localparam int LEN_W     = $clog2(LEN_MAX + 1);
  localparam int OFF_W     = $clog2(CL + 1);
  localparam int PDC_W     = (T_PDA > 1) ? $clog2(T_PDA + 1) : 1;

  logic [NUM_BANKS-1:0] bank_idle;
  logic                 bus_busy;
  logic                 ld_one;
  logic                 ld_all;
  logic [BA_W-1:0]      ld_bank;
  logic                 launch;
  logic                 launch_rd;
  logic [LEN_W-1:0]     launch_len;

  pcs_issue #(
    .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .UA_W(UA_W), .LA_W(LA_W),
    .RD_BURST(RD_BURST), .T_PDA(T_PDA), .LEN_W(LEN_W), .PDC_W(PDC_W)
  ) u_issue (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid_i), .req_type_i(req_type_i), .req_bank_i(req_bank_i),
    .req_uaddr_i(req_uaddr_i), .req_laddr_i(req_laddr_i), .req_vw_i(req_vw_i),
    .pd_req_i(pd_req_i), .bank_idle_i(bank_idle), .bus_busy_i(bus_busy),
    .grant_o(req_grant_o), .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o),
    .vw_o(vw_o), .pd_o(pd_o), .ld_one_o(ld_one), .ld_all_o(ld_all),
    .ld_bank_o(ld_bank), .launch_o(launch), .launch_rd_o(launch_rd),
    .launch_len_o(launch_len)
  );

  pcs_bank_timers #(
    .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .TW(TW), .T_IRC(T_IRC), .T_IREFC(T_IREFC)
  ) u_timers (
    .clk(clk), .rst(rst), .ld_one_i(ld_one), .ld_all_i(ld_all),
    .ld_bank_i(ld_bank), .idle_o(bank_idle)
  );

  pcs_data_window #(
    .CL(CL), .OFF_W(OFF_W), .LEN_W(LEN_W)
  ) u_window (
    .clk(clk), .rst(rst), .launch_i(launch), .launch_rd_i(launch_rd),
    .launch_len_i(launch_len), .busy_o(bus_busy), .rd_valid_o(rd_valid_o),
    .wr_en_o(wr_dq_en_o), .wr_strobe_o(wr_strobe_o)
  );

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_grant_o,
  input logic [2:0] cmd_o,
  input logic       pd_o,
  input logic       rd_valid_o,
  input logic       wr_dq_en_o,
  input logic       wr_strobe_o
);

  // R1: a read-open is always followed by lower address or mode set
  a_r1_rda_paired: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd1) |=> ((cmd_o == 3'd3) || (cmd_o == 3'd5)));

  // R2: a write-open is always followed by lower address or refresh
  a_r2_wra_paired: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd2) |=> ((cmd_o == 3'd3) || (cmd_o == 3'd4)));

  // R1: grant only alongside a first command
  a_r1_grant_first: assert property (@(posedge clk) disable iff (rst)
    req_grant_o |-> ((cmd_o == 3'd1) || (cmd_o == 3'd2)));

  // R10: a second command never stands alone
  a_r10_second_has_first: assert property (@(posedge clk) disable iff (rst)
    ((cmd_o == 3'd3) || (cmd_o == 3'd4) || (cmd_o == 3'd5)) |->
    (($past(cmd_o) == 3'd1) || ($past(cmd_o) == 3'd2)));

  // R11: only deselect while powered down
  a_r11_pd_desl: assert property (@(posedge clk) disable iff (rst)
    !pd_o |-> (cmd_o == 3'd0));

  // R12: wake-up cycle carries deselect
  a_r12_exit_desl: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_o) |-> (cmd_o == 3'd0));

  // R7: strobe lives inside the write window and alternates
  a_r7_strobe_in_window: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_o |-> wr_dq_en_o);

  a_r7_strobe_toggles: assert property (@(posedge clk) disable iff (rst)
    (wr_dq_en_o && $past(wr_dq_en_o)) |-> (wr_strobe_o != $past(wr_strobe_o)));

  // R9: read and write windows never overlap
  a_r9_one_window: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid_o && wr_dq_en_o));

endmodule

bind pair_cmd_seq pcs_checker u_chk (
  .clk(clk), .rst(rst), .req_grant_o(req_grant_o), .cmd_o(cmd_o), .pd_o(pd_o),
  .rd_valid_o(rd_valid_o), .wr_dq_en_o(wr_dq_en_o), .wr_strobe_o(wr_strobe_o)
);

// File: tb/sim_pair_cmd_seq.sv
`timescale 1ns/1ps
module sim_pair_cmd_seq;

  localparam int BA_W = 2, UA_W = 12, LA_W = 8;
  localparam int CL = 3, RDB = 2, T_IRC = 10, T_IREFC = 12, T_PDA = 3;
  localparam int NCYC = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_type = '0;
  logic [BA_W-1:0] req_bank = '0;
  logic [UA_W-1:0] req_uaddr = '0;
  logic [LA_W-1:0] req_laddr = '0;
  logic [1:0] req_vw = '0;
  logic pd_req = 1'b0;
  logic grant, pd_o, rd_valid, wr_en, wr_strobe;
  logic [2:0] cmd;
  logic [BA_W-1:0] ba;
  logic [UA_W-1:0] addr;
  logic [1:0] vw;

  always #4 clk = ~clk;

  pair_cmd_seq #(
    .BA_W(BA_W), .UA_W(UA_W), .LA_W(LA_W), .CL(CL), .RD_BURST(RDB),
    .T_IRC(T_IRC), .T_IREFC(T_IREFC), .T_PDA(T_PDA)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_type_i(req_type),
    .req_bank_i(req_bank), .req_uaddr_i(req_uaddr), .req_laddr_i(req_laddr),
    .req_vw_i(req_vw), .req_grant_o(grant), .pd_req_i(pd_req), .cmd_o(cmd),
    .ba_o(ba), .addr_o(addr), .vw_o(vw), .pd_o(pd_o), .rd_valid_o(rd_valid),
    .wr_dq_en_o(wr_en), .wr_strobe_o(wr_strobe)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [2:0]      c;
    logic [BA_W-1:0] b;
    logic [UA_W-1:0] a;
    logic [1:0]      v;
    string           tag;
  } item_t;

  item_t exp_q[$];
  bit exp_rd[NCYC];
  bit exp_we[NCYC];
  bit exp_st[NCYC];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input logic [2:0] c, input logic [BA_W-1:0] b,
                      input logic [UA_W-1:0] a, input logic [1:0] v, input string tag);
    item_t it;
    it.c = c; it.b = b; it.a = a; it.v = v; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // driver: push expected pair, then present the request
  task automatic start_req(input int t, input int b, input int u, input int l, input int v);
    @(negedge clk);
    case (t)
      0: begin push(3'd1, BA_W'(b), UA_W'(u), 2'd0, "R1"); push(3'd3, BA_W'(b), UA_W'(l), 2'd0, "R1"); end
      1: begin push(3'd2, BA_W'(b), UA_W'(u), 2'd0, "R2"); push(3'd3, BA_W'(b), UA_W'(l), 2'(v), "R2"); end
      2: begin push(3'd2, BA_W'(b), UA_W'(u), 2'd0, "R3"); push(3'd4, BA_W'(b), '0, 2'd0, "R3"); end
      default: begin push(3'd1, BA_W'(b), UA_W'(u), 2'd0, "R4"); push(3'd5, BA_W'(b), UA_W'(u), 2'd0, "R4"); end
    endcase
    req_valid = 1'b1;
    req_type  = 2'(t);
    req_bank  = BA_W'(b);
    req_uaddr = UA_W'(u);
    req_laddr = LA_W'(l);
    req_vw    = 2'(v);
  endtask

  task automatic wait_grant(output int g);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!grant && n < 2000);
    g = cyc;
    req_valid = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops expected commands and tracks expected data windows
  logic [2:0] last_first = 3'd0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (cyc < NCYC) begin
        chk(rd_valid == exp_rd[cyc], "R8 rd_valid", rd_valid, exp_rd[cyc]);
        chk(wr_en == exp_we[cyc], "R7 wr_dq_en", wr_en, exp_we[cyc]);
        chk(wr_strobe == exp_st[cyc], "R7 wr_strobe", wr_strobe, exp_st[cyc]);
      end
      if (cmd != 3'd0) begin
        chk(grant == ((cmd == 3'd1) || (cmd == 3'd2)), "R1 grant with first", grant, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected command", cmd, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(cmd == e.c, {e.tag, " cmd"}, cmd, e.c);
          chk(ba == e.b, {e.tag, " bank"}, ba, e.b);
          chk(addr == e.a, {e.tag, " addr"}, addr, e.a);
          chk(vw == e.v, {e.tag, " vw"}, vw, e.v);
        end
        if (cmd == 3'd3 && cyc + CL + 8 < NCYC) begin
          if (last_first == 3'd2) begin
            for (int i = 0; i < (1 << vw); i++) begin
              exp_we[cyc + CL - 1 + i] = 1'b1;
              exp_st[cyc + CL - 1 + i] = (i % 2 == 0);
            end
          end else begin
            for (int i = 0; i < RDB; i++) exp_rd[cyc + CL + i] = 1'b1;
          end
        end
        if (cmd == 3'd1 || cmd == 3'd2) last_first = cmd;
      end else begin
        chk(grant == 1'b0, "R10 grant on deselect", grant, 0);
      end
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int g1, g2, g3, g4, g5, g6, g7, g8, g9, g10, q;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(cmd == 3'd0, "R10 reset cmd", cmd, 0);
    chk(pd_o == 1'b1, "R10 reset pd", pd_o, 1);
    chk(grant == 1'b0, "R10 reset grant", grant, 0);

    start_req(0, 0, 12'h123, 8'h45, 0); wait_grant(g1);
    start_req(0, 1, 12'h2AB, 8'h17, 0); wait_grant(g2);
    chk(g2 == g1 + 7, "R9 read then other bank", g2 - g1, 7);
    start_req(0, 1, 12'h3C4, 8'hF0, 0); wait_grant(g3);
    chk(g3 == g2 + T_IRC, "R5 same bank repeat", g3 - g2, T_IRC);
    start_req(1, 2, 12'h055, 8'h3A, 2); wait_grant(g4);
    chk(g4 == g3 + 7, "R9 read then write", g4 - g3, 7);
    start_req(1, 3, 12'hFFF, 8'hC3, 0); wait_grant(g5);
    chk(g5 == g4 + 8, "R9 write burst 4 then write", g5 - g4, 8);
    start_req(2, 0, 0, 0, 0); wait_grant(g6);
    chk(g6 == g5 + T_IRC, "R3 refresh waits for all banks", g6 - g5, T_IRC);
    start_req(3, 1, 12'h0A5, 0, 0); wait_grant(g7);
    chk(g7 == g6 + 1 + T_IREFC, "R6 refresh hold-off", g7 - g6, 1 + T_IREFC);
    start_req(0, 0, 12'h777, 8'h01, 0); wait_grant(g8);
    chk(g8 == g7 + 2, "R9 back-to-back after mode set", g8 - g7, 2);

    // R11: power-down entry waits for quiet
    wait_until(g8 + 1);
    pd_req = 1'b1;
    wait_until(g8 + 9);
    chk(pd_o == 1'b1, "R11 pd held while busy", pd_o, 1);
    wait_until(g8 + 10);
    chk(pd_o == 1'b0, "R11 pd entered", pd_o, 0);
    start_req(0, 2, 12'h007, 8'h09, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(grant == 1'b0, "R11 no grant while down", grant, 0);
      chk(pd_o == 1'b0, "R11 pd stays low", pd_o, 0);
    end
    pd_req = 1'b0;
    q = cyc;
    @(negedge clk);
    chk(pd_o == 1'b1, "R12 pd released", pd_o, 1);
    wait_grant(g9);
    chk(g9 == q + 1 + T_PDA, "R12 wake-up deselect count", g9 - q, 1 + T_PDA);

    start_req(1, 2, 12'h8E1, 8'h66, 3); wait_grant(g10);
    chk(g10 == g9 + T_IRC, "R5 write after read same bank", g10 - g9, T_IRC);

    repeat (25) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all commands issued", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule